// File: doc/BRIEF.md
# Byte-Serial Masked AES-128 Encryption Core

This block encrypts one 128-bit block under a 128-bit key, keeping the data state in additively masked form from load to output. The caller supplies plaintext, key and two independent 128-bit random masks. One is the input-side mask, which hides each state byte entering the S-box. The other is the output-side mask, which hides each S-box result. Each state byte has its own mask byte in both masks.

Internally the data path is one byte wide. A single S-box is time-shared in a fixed per-round schedule. First it forms the first word of the next round key, without masking. Then it substitutes the sixteen masked state bytes, one column at a time. After each column, a 32-bit stage applies the column mix and the round key, and converts the column's mask from the output-side mask back to the input-side mask.

The state and its mask are held in byte-wise rotating registers that move in lockstep, so each mask byte stays with its data byte. The final round skips the column mix. The output-side mask is stripped only when the ciphertext is latched.

Top module: `masked_aes_byte_core`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `cipher_o` is all zeros.
- R2: With both masks zero, `cipher_o` equals the standard AES-128 result. Byte 0 of every 128-bit port is bits [127:120]. Examples: key 000102…0f with plaintext 00112233…ff gives 69c4e0d86a7b0430d8cdb78070b4c55a, and key and plaintext all zero give 66e94bd4ef8a2c3b884cfa59ca342b2e.
- R3: For any pair of mask values, the ciphertext is the same as with zero masks.
- R4: `done_o` is high for exactly one cycle, 251 rising edges after the edge that samples `start_i`. `busy_o` is high from that edge until the edge that raises `done_o`, and low while `done_o` is high.
- R5: `start_i` is ignored while `busy_o` is high. Changes to plaintext, key or masks during a run do not alter that run's result or its timing.
- R6: Each round takes 25 cycles, in this order: one ShiftRows cycle on the state and its mask, four S-box cycles for the key schedule, then four columns of four S-box cycles followed by one mix/round-key cycle.
- R7: `cipher_o` changes only in the cycle `done_o` rises, and holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an encryption; sampled only when idle |
| plain_i | input | 128 | Plaintext block |
| key_i | input | 128 | Cipher key |
| mask_in_i | input | 128 | Per-byte mask on the S-box input side |
| mask_out_i | input | 128 | Per-byte mask on the S-box output side |
| cipher_o | output | 128 | Unmasked ciphertext, held between runs |
| busy_o | output | 1 | Encryption in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the core with its default of ten rounds. Only that value makes the published AES-128 vectors apply and fixes the completion latency at 251 edges. With that setting, zero masks and several pseudo-random mask pairs can both be compared against the same known ciphertexts. Restart attempts and input changes are placed mid-run, and the latency is counted against the 25-cycle round schedule.

// File: rtl/maes_pkg.sv
package maes_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SHIFT, PH_KEY, PH_SUB, PH_MIX, PH_FIN
  } phase_e;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  // x^254 by square-and-multiply; maps 0 to 0
  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] e;
    r = 8'h01;
    e = 8'hfe;
    for (int i = 7; i >= 0; i--) begin
      r = gmul(r, r);
      if (e[i]) r = gmul(r, a);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int s);
    return (a << s) | (a >> (8 - s));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] v;
    v = ginv(x);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [3:0][7:0] mix(input logic [3:0][7:0] c);
    logic [3:0][7:0] o;
    for (int r = 0; r < 4; r++) begin
      o[r] = xtime(c[r]) ^ xtime(c[(r+1)%4]) ^ c[(r+1)%4] ^ c[(r+2)%4] ^ c[(r+3)%4];
    end
    return o;
  endfunction

endpackage

// File: rtl/maes_sbox_masked.sv
module maes_sbox_masked
  import maes_pkg::*;
(
  input  logic [7:0] in_i,
  input  logic [7:0] min_i,
  input  logic [7:0] mout_i,
  output logic [7:0] out_o
);
  // functional model: unmask, substitute, remask with the output mask
  assign out_o = sbox(in_i ^ min_i) ^ mout_i;
endmodule

// File: rtl/maes_mixcol.sv
module maes_mixcol
  import maes_pkg::*;
(
  input  logic            last_i,
  input  logic [3:0][7:0] sub_i,    // column bytes masked with mout
  input  logic [3:0][7:0] mout_i,
  input  logic [3:0][7:0] min_i,    // mask the column returns to
  input  logic [3:0][7:0] rkey_i,
  output logic [3:0][7:0] col_o
);
  logic [3:0][7:0] mixed_d;
  logic [3:0][7:0] mixed_m;

  assign mixed_d = mix(sub_i);
  assign mixed_m = mix(mout_i);

  always_comb begin
    for (int r = 0; r < 4; r++) begin
      if (last_i) col_o[r] = sub_i[r] ^ rkey_i[r];
      else        col_o[r] = mixed_d[r] ^ mixed_m[r] ^ min_i[r] ^ rkey_i[r];
    end
  end
endmodule

// File: rtl/maes_ctrl.sv
module maes_ctrl
  import maes_pkg::*;
#(
  parameter int NUM_ROUNDS = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output phase_e     phase_o,
  output logic [1:0] cnt_o,
  output logic [1:0] col_o,
  output logic       last_o,
  output logic [7:0] rcon_o,
  output logic       load_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int RND_W = $clog2(NUM_ROUNDS + 1);
  localparam logic [RND_W-1:0] RND_LAST = RND_W'(NUM_ROUNDS);

  phase_e           phase_q;
  logic [1:0]       cnt_q, col_q;
  logic [RND_W-1:0] rnd_q;
  logic [7:0]       rcon_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      col_q   <= '0;
      rnd_q   <= RND_W'(1);
      rcon_q  <= 8'h01;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_SHIFT;
          rnd_q   <= RND_W'(1);
          rcon_q  <= 8'h01;
          cnt_q   <= '0;
          col_q   <= '0;
        end
        PH_SHIFT: begin
          phase_q <= PH_KEY;
          cnt_q   <= '0;
        end
        PH_KEY: begin
          cnt_q <= cnt_q + 2'd1;
          if (cnt_q == 2'd3) begin
            phase_q <= PH_SUB;
            col_q   <= '0;
          end
        end
        PH_SUB: begin
          cnt_q <= cnt_q + 2'd1;
          if (cnt_q == 2'd3) phase_q <= PH_MIX;
        end
        PH_MIX: begin
          cnt_q <= '0;
          if (col_q == 2'd3) begin
            col_q <= '0;
            if (rnd_q == RND_LAST) phase_q <= PH_FIN;
            else begin
              phase_q <= PH_SHIFT;
              rnd_q   <= rnd_q + RND_W'(1);
              rcon_q  <= xtime(rcon_q);
            end
          end else begin
            col_q   <= col_q + 2'd1;
            phase_q <= PH_SUB;
          end
        end
        PH_FIN: begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
  assign col_o   = col_q;
  assign last_o  = (rnd_q == RND_LAST);
  assign rcon_o  = rcon_q;
  assign load_o  = (phase_q == PH_IDLE) && start_i;
  assign busy_o  = (phase_q != PH_IDLE);
  assign done_o  = done_q;

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_start_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && phase_q != PH_FIN && start_i) |=> (phase_q != PH_IDLE));

  assert_key_then_sub_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SUB && cnt_q == 2'd0) |->
      ($past(phase_q) == PH_KEY || $past(phase_q) == PH_MIX));

  assert_shift_then_key_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SHIFT) |=> (phase_q == PH_KEY && cnt_q == 2'd0));

endmodule

// File: rtl/masked_aes_byte_core.sv
module masked_aes_byte_core
  import maes_pkg::*;
#(
  parameter int NUM_ROUNDS = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [127:0] plain_i,
  input  logic [127:0] key_i,
  input  logic [127:0] mask_in_i,
  input  logic [127:0] mask_out_i,
  output logic [127:0] cipher_o,
  output logic         busy_o,
  output logic         done_o
);
  localparam int NB = 16;

  phase_e     phase;
  logic [1:0] cnt, col;
  logic       last, load;
  logic [7:0] rcon;

  maes_ctrl #(.NUM_ROUNDS(NUM_ROUNDS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .phase_o (phase),
    .cnt_o   (cnt),
    .col_o   (col),
    .last_o  (last),
    .rcon_o  (rcon),
    .load_o  (load),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  logic [7:0]   st_q  [NB];  // masked state, rotates during SubBytes
  logic [7:0]   mk_q  [NB];  // input-side mask, moves with the state
  logic [7:0]   nm_q  [NB];  // output-side mask, fixed per byte position
  logic [7:0]   key_q [NB];  // round key, unmasked
  logic [3:0][7:0] tw_q;     // S-box results for key word 0
  logic [3:0][7:0] cb_q;     // substituted column
  logic [127:0] ct_q;

  // shared S-box
  logic [7:0] sb_in, sb_min, sb_mout, sb_out;
  always_comb begin
    if (phase == PH_KEY) begin
      sb_in   = key_q[12 + ((int'(cnt) + 1) % 4)];
      sb_min  = 8'h00;
      sb_mout = 8'h00;
    end else begin
      sb_in   = st_q[0];
      sb_min  = mk_q[0];
      sb_mout = nm_q[{col, cnt}];
    end
  end

  maes_sbox_masked u_sbox (
    .in_i   (sb_in),
    .min_i  (sb_min),
    .mout_i (sb_mout),
    .out_o  (sb_out)
  );

  // next round-key word for the current column
  logic [3:0][7:0] kw_new;
  always_comb begin
    for (int r = 0; r < 4; r++) begin
      if (col == 2'd0)
        kw_new[r] = key_q[r] ^ tw_q[r] ^ ((r == 0) ? rcon : 8'h00);
      else
        kw_new[r] = key_q[4*(int'(col)-1)+r] ^ key_q[4*int'(col)+r];
    end
  end

  logic [3:0][7:0] col_m, col_n, col_out;
  always_comb begin
    for (int r = 0; r < 4; r++) begin
      col_m[r] = mk_q[12+r];
      col_n[r] = nm_q[4*int'(col)+r];
    end
  end

  maes_mixcol u_mix (
    .last_i (last),
    .sub_i  (cb_q),
    .mout_i (col_n),
    .min_i  (col_m),
    .rkey_i (kw_new),
    .col_o  (col_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NB; i++) begin
        st_q[i]  <= 8'h00;
        mk_q[i]  <= 8'h00;
        nm_q[i]  <= 8'h00;
        key_q[i] <= 8'h00;
      end
      tw_q <= '0;
      cb_q <= '0;
      ct_q <= '0;
    end else if (load) begin
      for (int i = 0; i < NB; i++) begin
        st_q[i]  <= plain_i[127-8*i -: 8] ^ mask_in_i[127-8*i -: 8] ^ key_i[127-8*i -: 8];
        mk_q[i]  <= mask_in_i[127-8*i -: 8];
        nm_q[i]  <= mask_out_i[127-8*i -: 8];
        key_q[i] <= key_i[127-8*i -: 8];
      end
    end else begin
      unique case (phase)
        PH_SHIFT: begin
          for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
              st_q[4*c+r] <= st_q[4*((c+r)%4)+r];
              mk_q[4*c+r] <= mk_q[4*((c+r)%4)+r];
            end
          end
        end
        PH_KEY: tw_q[cnt] <= sb_out;
        PH_SUB: begin
          for (int i = 0; i < NB-1; i++) begin
            st_q[i] <= st_q[i+1];
            mk_q[i] <= mk_q[i+1];
          end
          st_q[NB-1] <= st_q[0];
          mk_q[NB-1] <= mk_q[0];
          cb_q[cnt]  <= sb_out;
        end
        PH_MIX: begin
          for (int r = 0; r < 4; r++) begin
            st_q[12+r]             <= col_out[r];
            key_q[4*int'(col)+r]   <= kw_new[r];
          end
        end
        PH_FIN: begin
          for (int i = 0; i < NB; i++) ct_q[127-8*i -: 8] <= st_q[i] ^ nm_q[i];
        end
        default: ;
      endcase
    end
  end

  assign cipher_o = ct_q;

  assert_ct_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(cipher_o));

  assert_key_unmasked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_KEY) |-> (sb_min == 8'h00 && sb_mout == 8'h00));

endmodule

// File: tb/sim_masked_aes_byte_core.sv
module sim_masked_aes_byte_core;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_CYC = 252;  // negedges after start, done visible on this one

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] pt = '0, key = '0, mi = '0, mo = '0;
  logic [127:0] ct;
  logic         busy, done;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] seed = 32'h1234_5678;

  localparam logic [127:0] K_A  = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P_A  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C_A  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] K_B  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P_B  = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C_B  = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] C_Z  = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

  always #(CLK_PERIOD/2) clk = ~clk;

  masked_aes_byte_core u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .plain_i    (pt),
    .key_i      (key),
    .mask_in_i  (mi),
    .mask_out_i (mo),
    .cipher_o   (ct),
    .busy_o     (busy),
    .done_o     (done)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd32();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [127:0] rnd128();
    return {rnd32(), rnd32(), rnd32(), rnd32()};
  endfunction

  // start one run; return ciphertext, cycles to done and busy-high count before it
  task automatic run_enc(input logic [127:0] p, input logic [127:0] k,
                         input logic [127:0] a, input logic [127:0] b,
                         output logic [127:0] res, output int cyc, output int busy_cnt);
    @(negedge clk);
    pt = p; key = k; mi = a; mo = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    busy_cnt = 0;
    while (!done && cyc < 400) begin
      if (busy) busy_cnt++;
      @(negedge clk);
      cyc++;
    end
    res = ct;
  endtask

  task automatic test_reset();
    check(busy == 1'b0, "R1 busy", 128'(busy), 128'd0);
    check(done == 1'b0, "R1 done", 128'(done), 128'd0);
    check(ct == '0, "R1 cipher", ct, '0);
  endtask

  task automatic test_plain_vectors();
    logic [127:0] r;
    int cyc, bc;
    run_enc(P_A, K_A, '0, '0, r, cyc, bc);
    check(r == C_A, "R2 vector A", r, C_A);
    check(cyc == EXP_CYC, "R4 latency", 128'(cyc), 128'(EXP_CYC));
    check(bc == EXP_CYC - 1, "R6 busy cycles (25 per round)", 128'(bc), 128'(EXP_CYC - 1));
    check(busy == 1'b0, "R4 busy low at done", 128'(busy), 128'd0);
    @(negedge clk);
    check(done == 1'b0, "R4 done one cycle", 128'(done), 128'd0);
    run_enc(P_B, K_B, '0, '0, r, cyc, bc);
    check(r == C_B, "R2 vector B", r, C_B);
    run_enc('0, '0, '0, '0, r, cyc, bc);
    check(r == C_Z, "R2 zero vector", r, C_Z);
  endtask

  task automatic test_masked();
    logic [127:0] r;
    int cyc, bc;
    for (int i = 0; i < 4; i++) begin
      run_enc(P_A, K_A, rnd128(), rnd128(), r, cyc, bc);
      check(r == C_A, "R3 masked vector A", r, C_A);
      run_enc(P_B, K_B, rnd128(), rnd128(), r, cyc, bc);
      check(r == C_B, "R3 masked vector B", r, C_B);
    end
    run_enc(P_A, K_A, {128{1'b1}}, {128{1'b1}}, r, cyc, bc);
    check(r == C_A, "R3 all-ones masks", r, C_A);
    check(cyc == EXP_CYC, "R4 latency masked", 128'(cyc), 128'(EXP_CYC));
  endtask

  task automatic test_restart_ignored();
    int cyc;
    @(negedge clk);
    pt = P_B; key = K_B; mi = rnd128(); mo = rnd128(); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 400) begin
      if (cyc == 30 || cyc == 200 || cyc == 251) begin
        pt = P_A; key = K_A; mi = rnd128(); mo = rnd128(); start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(ct == C_B, "R5 restart ignored", ct, C_B);
    check(cyc == EXP_CYC, "R5 latency unchanged", 128'(cyc), 128'(EXP_CYC));
    @(negedge clk);
    check(busy == 1'b0, "R5 no second run", 128'(busy), 128'd0);
  endtask

  task automatic test_hold();
    logic [127:0] r;
    int cyc, bc;
    run_enc(P_A, K_A, rnd128(), rnd128(), r, cyc, bc);
    pt = '0; key = '0; mi = rnd128(); mo = rnd128();
    repeat (20) @(negedge clk);
    check(ct == C_A, "R7 cipher held while idle", ct, C_A);
    @(negedge clk);
    pt = P_B; key = K_B; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    check(ct == C_A, "R7 cipher held while busy", ct, C_A);
    while (!done) @(negedge clk);
    check(ct == C_B, "R7 cipher updated at done", ct, C_B);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 128'd0, 128'd1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_plain_vectors();
    test_masked();
    test_restart_ignored();
    test_hold();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule